// File: doc/BRIEF.md
# Back-EMF Zero-Crossing Analyser

This block sits between a terminal-voltage sampler and a six-step commutation controller for a three-phase brushless motor. Each time a new set of three unsigned terminal-voltage samples arrives, it rebuilds the motor's hidden star point from the three samples. It then derives a back-EMF value for every phase. The phase that the present commutation step leaves undriven is the only one whose value is meaningful. On that phase the block watches for a crossing of zero in the direction the step predicts, and emits a one-cycle pulse with the direction when it finds one.

Every phase's back-EMF is given scaled by three, as `3*V_phase - (V_a + V_b + V_c)`, so no divider is needed. The block keeps a running minimum and maximum of the scaled value for each phase over the current step. A commutation strobe loads the new step, clears the statistics and starts a programmable blanking window. Samples inside that window, which may carry inductive spikes, are discarded. A hysteresis band around zero stops noise from creating false crossings.

Top module: `bemf_zc_analyser`

## Requirements
- R1: After synchronous reset, `zc_pulse`, `zc_rising` and all six extrema outputs are 0, and no crossing can be reported until the first commutation strobe has loaded a step.
- R2: For every counted sample, phase p's scaled back-EMF is `3*V_p - (V_a+V_b+V_c)`. This is a signed value. The first counted sample of a step loads both the minimum and the maximum of every phase. Later counted samples lower the minimum or raise the maximum. Results show one clock after the sample.
- R3: Step index s selects the floating phase: steps 0 and 3 select phase C, steps 1 and 4 select phase B, and steps 2 and 5 select phase A. Only that phase is evaluated for crossings.
- R4: Odd steps expect a rising crossing, from below the band to above it. Even steps expect a falling crossing. A crossing in the other direction produces no pulse. `zc_rising` gives the direction of the most recent pulse.
- R5: On a commutation strobe, the block latches `blank_n`. The next `blank_n` valid samples are ignored for both crossing detection and extrema.
- R6: At most one `zc_pulse` occurs per commutation step. Each pulse lasts exactly one cycle and comes one clock after the sample that completes the crossing.
- R7: A commutation strobe sets all six extrema outputs to 0 on the next clock and forgets the previous side of the floating phase.
- R8: A sample is above the band when its scaled value is greater than `hyst`, and below it when its scaled value is less than `-hyst`. Otherwise it is inside the band and leaves the recorded side unchanged. A crossing needs a recorded side on one side of the band and a new sample on the other side.
- R9: A sample that arrives in the same cycle as a commutation strobe is discarded entirely.
- R10: Step indices 6 and 7 are invalid. While one of them is loaded, no crossing is reported, although the extrema are still tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A fresh set of three samples is present |
| volt_a | input | VW | Terminal voltage, phase A (unsigned) |
| volt_b | input | VW | Terminal voltage, phase B (unsigned) |
| volt_c | input | VW | Terminal voltage, phase C (unsigned) |
| commutate | input | 1 | Commutation strobe; loads `step_idx`, `blank_n`, and restarts tracking |
| step_idx | input | 3 | Index of the step that begins with this strobe |
| blank_n | input | BW | Number of samples to discard after the strobe |
| hyst | input | VW+1 | Hysteresis half-width in scaled units |
| zc_pulse | output | 1 | One-cycle crossing report |
| zc_rising | output | 1 | Direction of the last crossing (1 = rising) |
| emf_min_a | output | VW+3 | Signed minimum scaled back-EMF, phase A |
| emf_min_b | output | VW+3 | Signed minimum, phase B |
| emf_min_c | output | VW+3 | Signed minimum, phase C |
| emf_max_a | output | VW+3 | Signed maximum, phase A |
| emf_max_b | output | VW+3 | Signed maximum, phase B |
| emf_max_c | output | VW+3 | Signed maximum, phase C |

## Verification
A wrong blanking count or a wrong stored step shows up at the next crossing. The pulse then comes one sample early or late, comes on the wrong phase, or does not come at all. The reference model flags this in the cycle the pulse is due. A corrupted side or done flag gives a missing or repeated pulse within one step. A wrong extrema register differs from the model's minimum or maximum one clock after the first counted sample of a step. All outputs are compared on every clock, so a fault is reported in the cycle it first reaches a port.

// File: rtl/bemf_pkg.sv
package bemf_pkg;

    localparam int NPH      = 3;
    localparam int STEP_W   = 3;
    localparam int NSTEPS   = 6;
    localparam int PH_A     = 0;
    localparam int PH_B     = 1;
    localparam int PH_C     = 2;

    // Which side of the hysteresis band the floating phase was last seen on
    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_LOW  = 2'd1,
        SIDE_HIGH = 2'd2
    } side_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] phase;
        logic       rising;
    } step_info_t;

    // Six-step table: floating phase cycles C, B, A; odd steps rise.
    function automatic step_info_t decode_step(input logic [STEP_W-1:0] s);
        step_info_t r;
        r.valid  = (s < STEP_W'(NSTEPS));
        r.rising = s[0];
        case (s)
            3'd0, 3'd3: r.phase = 2'(PH_C);
            3'd1, 3'd4: r.phase = 2'(PH_B);
            3'd2, 3'd5: r.phase = 2'(PH_A);
            default:    r.phase = 2'(PH_A);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bemf_scale.sv
module bemf_scale
    import bemf_pkg::*;
#(
    parameter int VW = 10,
    parameter int EW = VW + 3
) (
    input  logic [NPH-1:0][VW-1:0] volt,
    output logic [NPH-1:0][EW-1:0] emf
);

    logic [EW-1:0] sum;

    always_comb begin
        sum = '0;
        for (int p = 0; p < NPH; p++) begin
            sum = sum + EW'(volt[p]);
        end
    end

    // 3*V_p - sum equals 3*(V_p - neutral): exact, no divider.
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic [EW-1:0] trip;
        assign trip   = (EW'(volt[p]) << 1) + EW'(volt[p]);
        assign emf[p] = trip - sum;
    end

endmodule

// File: rtl/bemf_blanker.sv
module bemf_blanker #(
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commutate,
    input  logic          smp_valid,
    input  logic [BW-1:0] blank_n,
    output logic          sample_use
);

    logic [BW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (commutate) begin
            left_q <= blank_n;
        end else if (smp_valid && (left_q != '0)) begin
            left_q <= left_q - BW'(1);
        end
    end

    assign sample_use = smp_valid && !commutate && (left_q == '0);

endmodule

// File: rtl/bemf_zc_detect.sv
module bemf_zc_detect
    import bemf_pkg::*;
#(
    parameter int EW = 13,
    parameter int HW = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   commutate,
    input  logic [STEP_W-1:0]      step_idx,
    input  logic [HW-1:0]          hyst,
    input  logic                   sample_use,
    input  logic [NPH-1:0][EW-1:0] emf,
    output logic                   zc_pulse,
    output logic                   zc_rising
);

    logic [STEP_W-1:0] step_q;
    side_e             side_q;
    logic              done_q;

    step_info_t        info;
    logic signed [EW-1:0] fl, hpos, hneg;
    side_e             cur;
    logic              hit;

    always_comb begin
        info = decode_step(step_q);
        fl   = $signed(emf[info.phase]);
        hpos = $signed({{(EW-HW){1'b0}}, hyst});
        hneg = -hpos;
        if (fl > hpos)      cur = SIDE_HIGH;
        else if (fl < hneg) cur = SIDE_LOW;
        else                cur = SIDE_NONE;
        hit = sample_use && info.valid && !done_q &&
              (( info.rising && side_q == SIDE_LOW  && cur == SIDE_HIGH) ||
               (!info.rising && side_q == SIDE_HIGH && cur == SIDE_LOW));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= STEP_W'(7);
            side_q    <= SIDE_NONE;
            done_q    <= 1'b0;
            zc_pulse  <= 1'b0;
            zc_rising <= 1'b0;
        end else begin
            zc_pulse <= hit;
            if (commutate) begin
                step_q <= step_idx;
                side_q <= SIDE_NONE;
                done_q <= 1'b0;
            end else if (sample_use && info.valid) begin
                if (cur != SIDE_NONE) side_q <= cur;
                if (hit) begin
                    done_q    <= 1'b1;
                    zc_rising <= info.rising;
                end
            end
        end
    end

endmodule

// File: rtl/bemf_extrema.sv
module bemf_extrema
    import bemf_pkg::*;
#(
    parameter int EW = 13
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   commutate,
    input  logic                   sample_use,
    input  logic [NPH-1:0][EW-1:0] emf,
    output logic [NPH-1:0][EW-1:0] mins,
    output logic [NPH-1:0][EW-1:0] maxs
);

    logic first_q;

    always_ff @(posedge clk) begin
        if (rst || commutate) first_q <= 1'b1;
        else if (sample_use)  first_q <= 1'b0;
    end

    for (genvar p = 0; p < NPH; p++) begin : g_track
        always_ff @(posedge clk) begin
            if (rst || commutate) begin
                mins[p] <= '0;
                maxs[p] <= '0;
            end else if (sample_use) begin
                if (first_q || ($signed(emf[p]) < $signed(mins[p]))) mins[p] <= emf[p];
                if (first_q || ($signed(emf[p]) > $signed(maxs[p]))) maxs[p] <= emf[p];
            end
        end
    end

endmodule

// File: rtl/bemf_zc_analyser.sv
module bemf_zc_analyser
    import bemf_pkg::*;
#(
    parameter int VW = 10,
    parameter int BW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic [VW-1:0]        volt_a,
    input  logic [VW-1:0]        volt_b,
    input  logic [VW-1:0]        volt_c,
    input  logic                 commutate,
    input  logic [2:0]           step_idx,
    input  logic [BW-1:0]        blank_n,
    input  logic [VW:0]          hyst,
    output logic                 zc_pulse,
    output logic                 zc_rising,
    output logic signed [VW+2:0] emf_min_a,
    output logic signed [VW+2:0] emf_min_b,
    output logic signed [VW+2:0] emf_min_c,
    output logic signed [VW+2:0] emf_max_a,
    output logic signed [VW+2:0] emf_max_b,
    output logic signed [VW+2:0] emf_max_c
);

    localparam int EW = VW + 3;
    localparam int HW = VW + 1;

    logic [NPH-1:0][VW-1:0] volt;
    logic [NPH-1:0][EW-1:0] emf, mins, maxs;
    logic                   sample_use;

    assign volt[PH_A] = volt_a;
    assign volt[PH_B] = volt_b;
    assign volt[PH_C] = volt_c;

    bemf_scale #(.VW(VW), .EW(EW)) u_scale (
        .volt (volt),
        .emf  (emf)
    );

    bemf_blanker #(.BW(BW)) u_blank (
        .clk        (clk),
        .rst        (rst),
        .commutate  (commutate),
        .smp_valid  (smp_valid),
        .blank_n    (blank_n),
        .sample_use (sample_use)
    );

    bemf_zc_detect #(.EW(EW), .HW(HW)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .commutate  (commutate),
        .step_idx   (step_idx),
        .hyst       (hyst),
        .sample_use (sample_use),
        .emf        (emf),
        .zc_pulse   (zc_pulse),
        .zc_rising  (zc_rising)
    );

    bemf_extrema #(.EW(EW)) u_ext (
        .clk        (clk),
        .rst        (rst),
        .commutate  (commutate),
        .sample_use (sample_use),
        .emf        (emf),
        .mins       (mins),
        .maxs       (maxs)
    );

    assign emf_min_a = $signed(mins[PH_A]);
    assign emf_min_b = $signed(mins[PH_B]);
    assign emf_min_c = $signed(mins[PH_C]);
    assign emf_max_a = $signed(maxs[PH_A]);
    assign emf_max_b = $signed(maxs[PH_B]);
    assign emf_max_c = $signed(maxs[PH_C]);

endmodule

// File: rtl/bemf_zc_analyser_chk.sv
module bemf_zc_analyser_chk #(
    parameter int VW = 10,
    parameter int BW = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_valid,
    input logic                 commutate,
    input logic [BW-1:0]        blank_n,
    input logic                 zc_pulse,
    input logic signed [VW+2:0] emf_min_a,
    input logic signed [VW+2:0] emf_min_b,
    input logic signed [VW+2:0] emf_min_c,
    input logic signed [VW+2:0] emf_max_a,
    input logic signed [VW+2:0] emf_max_b,
    input logic signed [VW+2:0] emf_max_c
);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        zc_pulse |=> !zc_pulse);

    a_r9_pulse_from_sample: assert property (@(posedge clk) disable iff (rst)
        zc_pulse |-> ($past(smp_valid) && !$past(commutate)));

    a_r7_clear_on_commutate: assert property (@(posedge clk) disable iff (rst)
        commutate |=> (emf_min_a == 0 && emf_min_b == 0 && emf_min_c == 0 &&
                       emf_max_a == 0 && emf_max_b == 0 && emf_max_c == 0));

    a_r2_min_le_max: assert property (@(posedge clk) disable iff (rst)
        (emf_min_a <= emf_max_a) && (emf_min_b <= emf_max_b) && (emf_min_c <= emf_max_c));

    a_r5_blank_window: assert property (@(posedge clk) disable iff (rst)
        (commutate && blank_n != '0) |=> ##1 !zc_pulse);

endmodule

bind bemf_zc_analyser bemf_zc_analyser_chk #(.VW(VW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .commutate (commutate),
    .blank_n   (blank_n),
    .zc_pulse  (zc_pulse),
    .emf_min_a (emf_min_a),
    .emf_min_b (emf_min_b),
    .emf_min_c (emf_min_c),
    .emf_max_a (emf_max_a),
    .emf_max_b (emf_max_b),
    .emf_max_c (emf_max_c)
);

// File: tb/bemf_zc_analyser_bench.sv
`timescale 1ns/1ps
module bemf_zc_analyser_bench;

    localparam int VW = 10;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [VW-1:0] volt_a = '0, volt_b = '0, volt_c = '0;
    logic commutate = 1'b0;
    logic [2:0] step_idx = '0;
    logic [BW-1:0] blank_n = '0;
    logic [VW:0] hyst = '0;
    logic zc_pulse, zc_rising;
    logic signed [VW+2:0] emf_min_a, emf_min_b, emf_min_c;
    logic signed [VW+2:0] emf_max_a, emf_max_b, emf_max_c;

    always #4 clk = ~clk;

    bemf_zc_analyser #(.VW(VW), .BW(BW)) u_bemf_zc_analyser (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .volt_a(volt_a), .volt_b(volt_b), .volt_c(volt_c),
        .commutate(commutate), .step_idx(step_idx), .blank_n(blank_n), .hyst(hyst),
        .zc_pulse(zc_pulse), .zc_rising(zc_rising),
        .emf_min_a(emf_min_a), .emf_min_b(emf_min_b), .emf_min_c(emf_min_c),
        .emf_max_a(emf_max_a), .emf_max_b(emf_max_b), .emf_max_c(emf_max_c)
    );

    int n_vec = 0;
    int n_bad = 0;
    int pcount = 0;
    bit done_run = 0;

    // ---------------- behavioural reference model ----------------
    int m_step = 7, m_left = 0, m_side = 0, m_done = 0, m_first = 1;
    int m_min[3] = '{0, 0, 0};
    int m_max[3] = '{0, 0, 0};
    int m_pulse = 0, m_rise = 0;

    always @(posedge clk) begin
        int e[3];
        int f, cur, h;
        bit rising;
        if (rst) begin
            m_step = 7; m_left = 0; m_side = 0; m_done = 0; m_first = 1;
            m_min = '{0, 0, 0}; m_max = '{0, 0, 0}; m_pulse = 0; m_rise = 0;
        end else if (commutate) begin
            m_step = int'(step_idx); m_left = int'(blank_n); m_side = 0; m_done = 0;
            m_first = 1; m_min = '{0, 0, 0}; m_max = '{0, 0, 0}; m_pulse = 0;
        end else if (smp_valid && m_left > 0) begin
            m_left--; m_pulse = 0;
        end else if (smp_valid) begin
            e[0] = 2*int'(volt_a) - int'(volt_b) - int'(volt_c);
            e[1] = 2*int'(volt_b) - int'(volt_a) - int'(volt_c);
            e[2] = 2*int'(volt_c) - int'(volt_a) - int'(volt_b);
            for (int p = 0; p < 3; p++) begin
                if (m_first || e[p] < m_min[p]) m_min[p] = e[p];
                if (m_first || e[p] > m_max[p]) m_max[p] = e[p];
            end
            m_first = 0;
            m_pulse = 0;
            if (m_step < 6) begin
                f = (m_step % 3 == 0) ? 2 : ((m_step % 3 == 1) ? 1 : 0);
                rising = (m_step % 2 == 1);
                h = int'(hyst);
                cur = (e[f] > h) ? 2 : ((e[f] < -h) ? 1 : 0);
                if (!m_done && ((rising && m_side == 1 && cur == 2) ||
                                (!rising && m_side == 2 && cur == 1))) begin
                    m_pulse = 1; m_done = 1; m_rise = rising ? 1 : 0;
                end
                if (cur != 0) m_side = cur;
            end
        end else begin
            m_pulse = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_run) begin
            check("R3/R4/R5/R6/R8/R10 zc_pulse", int'(zc_pulse), m_pulse);
            if (zc_pulse && m_pulse == 1) check("R4 zc_rising", int'(zc_rising), m_rise);
            check("R2/R7 min_a", int'(emf_min_a), m_min[0]);
            check("R2/R7 min_b", int'(emf_min_b), m_min[1]);
            check("R2/R7 min_c", int'(emf_min_c), m_min[2]);
            check("R2/R7 max_a", int'(emf_max_a), m_max[0]);
            check("R2/R7 max_b", int'(emf_max_b), m_max[1]);
            check("R2/R7 max_c", int'(emf_max_c), m_max[2]);
            if (zc_pulse) pcount++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic comm(input int s, input int b, input int h);
        commutate = 1; step_idx = 3'(s); blank_n = BW'(b); hyst = (VW+1)'(h); smp_valid = 0;
        @(negedge clk);
        commutate = 0;
    endtask

    task automatic smp(input int a, input int b, input int c);
        smp_valid = 1; volt_a = VW'(a); volt_b = VW'(b); volt_c = VW'(c);
        @(negedge clk);
        smp_valid = 0;
    endtask

    task automatic settle_and_count(input string tag, input int exp);
        @(negedge clk); @(negedge clk);
        check(tag, pcount, exp);
        pcount = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1 zc_pulse after reset", int'(zc_pulse), 0);
        check("R1 max_c after reset", int'(emf_max_c), 0);
        // R1: no step loaded yet, crossing pattern yields nothing
        smp(600, 200, 500); smp(600, 200, 300);
        settle_and_count("R1 no pulse before first step", 0);

        // R5/R4: step 0, floating C falling, blank 2
        comm(0, 2, 0);
        smp(600, 200, 300); smp(600, 200, 500);   // blanked
        smp(600, 200, 500); smp(600, 200, 450); smp(600, 200, 350);
        smp(600, 200, 500); smp(600, 200, 300);   // R6 second crossing suppressed
        settle_and_count("R5/R6 step0 falling count", 1);
        check("R4 direction falling", int'(zc_rising), 0);

        // R3/R4: step 1, floating B rising; wrong-direction first
        comm(1, 0, 0);
        smp(600, 500, 200); smp(600, 300, 200); smp(600, 500, 200);
        settle_and_count("R3/R4 step1 rising count", 1);
        check("R4 direction rising", int'(zc_rising), 1);

        // R8: hysteresis 100 on step 3 (C rising)
        comm(3, 0, 100);
        smp(600, 200, 380); smp(600, 200, 420); smp(600, 200, 350);
        @(negedge clk);
        check("R8 no pulse inside band", pcount, 0);
        smp(600, 200, 340); smp(600, 200, 420); smp(600, 200, 460);
        settle_and_count("R8 hysteresis count", 1);

        // R10: invalid step
        comm(6, 0, 0);
        smp(600, 200, 300); smp(600, 200, 500); smp(600, 200, 300);
        settle_and_count("R10 invalid step count", 0);

        // R9: sample coinciding with commutation is dropped
        commutate = 1; step_idx = 3'd0; blank_n = '0; hyst = '0;
        smp_valid = 1; volt_a = VW'(600); volt_b = VW'(200); volt_c = VW'(500);
        @(negedge clk);
        commutate = 0; smp_valid = 0;
        smp(600, 200, 350); smp(600, 200, 300);
        settle_and_count("R9 coincident sample dropped", 0);
        check("R2 min_a", int'(emf_min_a), 650);
        check("R2 max_a", int'(emf_max_a), 700);
        check("R2 max_c", int'(emf_max_c), -100);
        check("R2 min_c", int'(emf_min_c), -200);
        comm(2, 0, 0);
        @(negedge clk);
        check("R7 cleared max_a", int'(emf_max_a), 0);

        // random phase, reference model compares every clock
        for (int i = 0; i < 4000; i++) begin
            commutate = (($urandom % 16) == 0);
            step_idx  = 3'($urandom % 8);
            blank_n   = BW'($urandom % 4);
            hyst      = (VW+1)'($urandom % 64);
            smp_valid = (($urandom % 3) != 0);
            volt_a    = VW'(400 + $urandom % 300);
            volt_b    = VW'(400 + $urandom % 300);
            volt_c    = VW'(400 + $urandom % 300);
            @(negedge clk);
        end
        commutate = 0; smp_valid = 0;
        repeat (3) @(negedge clk);
        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done_run = 1;
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule